// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Guard

This block sits beside the command pins of a two-bank synchronous graphics DRAM. On every rising clock edge it samples the row strobe, column strobe, write strobe, special-function pin, bank select and ten address bits. It decodes the command those levels form and reports the decoded code one cycle later. It holds the device's mode register: burst length, addressing mode and CAS latency.

The block also tracks one lockout window per bank. A window starts when a write with auto-precharge or a block write with auto-precharge is accepted. Any command that breaks a lockout, the mode-register rules or the power-up ordering raises a one-cycle violation flag, and the block then discards that command.

A controller or a monitor uses the outputs to confirm that the command stream is legal. The write-recovery, row-precharge and block-write periods are parameters counted in clock cycles.

Top module: `gdram_cmd_guard`

## Requirements
- R1: Pin levels are given as (row, col, wr, spec), with 1 meaning high. The block decodes them as follows:
  - 111x: NOP (code 0).
  - 0110: ACT (1).
  - 1010: RD (2).
  - 1000: WR (3) when addr[9]=0, or WRAP (4) when addr[9]=1.
  - 1011: BW (5) when addr[9]=0, or BWAP (6) when addr[9]=1.
  - 0000: MRS (7).
  - 010x: PRE (8).
  - 001x: REF (9).
  - Every other pattern: OTH (10).

  cmd_q shows the code in the cycle after the edge that sampled the pins, and viol_q shows that command's verdict in the same cycle.
- R2: An accepted MRS loads mode_word with {bank_sel, addr_in[9:0]} and sets mode_valid. Both are visible in the next cycle. The fields are: burst code = mode_word[2:0] (0,1,2,3 give 1,2,4,8 beats; 7 is full page), addressing mode = mode_word[3], CAS latency = mode_word[6:4].
- R3: An MRS whose burst code is 4, 5 or 6, or whose CAS latency is 0 or 4 to 7, is a violation.
- R4: ACT, RD, WR, WRAP, BW or BWAP issued before any MRS has been accepted is a violation.
- R5: An accepted WRAP with a burst that is not full page makes the addressed bank busy for N = burst + TWR + TRP cycles. bank_busy[b] is high in cycles t+1 to t+N-1. A non-NOP command addressed to that bank is a violation at cycle t+N-1 and legal at cycle t+N.
- R6: A WRAP accepted while the burst code is full page starts no lockout, and bank_busy stays low.
- R7: An accepted BWAP makes the addressed bank busy for N = TBPL + TRP cycles, with the same boundary behaviour as R5.
- R8: MRS or REF while either bank is busy is a violation. A busy bank does not block commands addressed to the other bank.
- R9: Any non-NOP command in the cycle right after an accepted MRS is a violation.
- R10: A violating command has no effect. It loads no lockout and does not change the mode register.
- R11: Reset (synchronous, active high) clears cmd_q to NOP, viol_q, bank_busy, mode_word and mode_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_stb | input | 1 | Row strobe pin level |
| col_stb | input | 1 | Column strobe pin level |
| wr_stb | input | 1 | Write strobe pin level |
| spec_fn | input | 1 | Special-function (block write) pin level |
| bank_sel | input | 1 | Bank select |
| addr_in | input | 10 | Address pins |
| cmd_q | output | 4 | Decoded command code (R1) |
| viol_q | output | 1 | One-cycle violation flag |
| bank_busy | output | 2 | Per-bank lockout active |
| mode_word | output | 11 | Mode register contents |
| mode_valid | output | 1 | Mode register has been written |

## Verification
The bench issues commands exactly at the lockout boundary and one cycle before it, for a 2-beat burst, for full page and for block write.
- A counter that is off by one would flag the legal cycle, or let the early one through.
- A design that ignored full page would show bank_busy high after a full-page write.

The bench also tries rejected mode writes, writes made while a bank is busy, and commands right after a mode write. A design that applied a rejected command would show a changed mode_word or a spurious busy bank. Long random streams are compared each cycle with a bench model of the requirements.

// File: rtl/gdram_guard_pkg.sv
package gdram_guard_pkg;

    localparam int NBANK  = 2;
    localparam int ADDR_W = 10;
    localparam logic [2:0] BL_FULL = 3'd7;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_WRAP = 4'd4,
        CMD_BW   = 4'd5,
        CMD_BWAP = 4'd6,
        CMD_MRS  = 4'd7,
        CMD_PRE  = 4'd8,
        CMD_REF  = 4'd9,
        CMD_OTH  = 4'd10
    } cmd_e;

    typedef struct packed {
        logic              row;
        logic              col;
        logic              wr;
        logic              spec;
        logic              bank;
        logic [ADDR_W-1:0] addr;
    } pins_t;

    typedef struct packed {
        logic       bsel;
        logic [2:0] spare;
        logic [2:0] cas;
        logic       wrap;
        logic [2:0] blen;
    } mode_t;

    function automatic cmd_e decode_cmd(input pins_t p);
        cmd_e c;
        case ({p.row, p.col, p.wr})
            3'b111:  c = CMD_NOP;
            3'b011:  c = p.spec ? CMD_OTH : CMD_ACT;
            3'b101:  c = p.spec ? (p.addr[9] ? CMD_BWAP : CMD_BW) : CMD_RD;
            3'b100:  c = p.spec ? CMD_OTH : (p.addr[9] ? CMD_WRAP : CMD_WR);
            3'b000:  c = p.spec ? CMD_OTH : CMD_MRS;
            3'b010:  c = CMD_PRE;
            3'b001:  c = CMD_REF;
            default: c = CMD_OTH;
        endcase
        return c;
    endfunction

    function automatic logic blen_ok(input logic [2:0] code);
        return (code <= 3'd3) || (code == BL_FULL);
    endfunction

    function automatic logic cas_ok(input logic [2:0] lat);
        return (lat >= 3'd1) && (lat <= 3'd3);
    endfunction

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_ACT) || (c == CMD_RD) || (c == CMD_WR) ||
               (c == CMD_WRAP) || (c == CMD_BW) || (c == CMD_BWAP);
    endfunction

    function automatic logic is_global(input cmd_e c);
        return (c == CMD_MRS) || (c == CMD_REF);
    endfunction

endpackage

// File: rtl/gdram_cmd_dec.sv
module gdram_cmd_dec
    import gdram_guard_pkg::*;
(
    input  pins_t pins,
    output cmd_e  cmd
);
    always_comb begin
        cmd = decode_cmd(pins);
    end
endmodule

// File: rtl/gdram_mode_reg.sv
module gdram_mode_reg
    import gdram_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  mode_t wr_data,
    output mode_t mode_q,
    output logic  valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            valid_q <= 1'b0;
        end else if (wr_en) begin
            mode_q  <= wr_data;
            valid_q <= 1'b1;
        end
    end
endmodule

// File: rtl/gdram_bank_timer.sv
module gdram_bank_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/gdram_cmd_guard.sv
module gdram_cmd_guard
    import gdram_guard_pkg::*;
#(
    parameter int TWR  = 2,
    parameter int TRP  = 3,
    parameter int TBPL = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        row_stb,
    input  logic        col_stb,
    input  logic        wr_stb,
    input  logic        spec_fn,
    input  logic        bank_sel,
    input  logic [9:0]  addr_in,
    output logic [3:0]  cmd_q,
    output logic        viol_q,
    output logic [1:0]  bank_busy,
    output logic [10:0] mode_word,
    output logic        mode_valid
);
    localparam int MAX_WIN = 8 + TWR + TRP + TBPL;
    localparam int CNT_W   = $clog2(MAX_WIN + 1);

    pins_t pins;
    cmd_e  cmd_d;
    cmd_e  cmd_r;
    mode_t mode_cur;
    mode_t mode_new;
    logic  mrs_pend;
    logic  v_lock, v_gap, v_init, v_field, viol_d, accept;
    logic  wr_lock;
    logic [CNT_W-1:0] wr_win, bw_win, win_sel;
    logic [NBANK-1:0] busy;
    logic [NBANK-1:0] load;

    assign pins = '{row: row_stb, col: col_stb, wr: wr_stb, spec: spec_fn,
                    bank: bank_sel, addr: addr_in};

    gdram_cmd_dec u_dec (
        .pins (pins),
        .cmd  (cmd_d)
    );

    assign mode_new = mode_t'({bank_sel, addr_in});

    // Lockout lengths, loaded as N-1 so the bank is free on the Nth cycle.
    always_comb begin
        wr_win = CNT_W'((32'd1 << mode_cur.blen[1:0]) + TWR + TRP - 1);
        bw_win = CNT_W'(TBPL + TRP - 1);
    end

    always_comb begin
        v_lock  = 1'b0;
        if (is_global(cmd_d))
            v_lock = |busy;
        else if (cmd_d != CMD_NOP)
            v_lock = busy[bank_sel];
        v_gap   = mrs_pend && (cmd_d != CMD_NOP);
        v_init  = !mode_valid && is_access(cmd_d);
        v_field = (cmd_d == CMD_MRS) && !(blen_ok(addr_in[2:0]) && cas_ok(addr_in[6:4]));
        viol_d  = v_lock | v_gap | v_init | v_field;
        accept  = (cmd_d != CMD_NOP) && !viol_d;
        wr_lock = (cmd_d == CMD_WRAP) && (mode_cur.blen != BL_FULL);
        win_sel = (cmd_d == CMD_BWAP) ? bw_win : wr_win;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign load[b] = accept && (bank_sel == b[0]) &&
                         (wr_lock || (cmd_d == CMD_BWAP));
        gdram_bank_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .load     (load[b]),
            .load_val (win_sel),
            .busy     (busy[b])
        );
    end

    gdram_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept && (cmd_d == CMD_MRS)),
        .wr_data (mode_new),
        .mode_q  (mode_cur),
        .valid_q (mode_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_r    <= CMD_NOP;
            viol_q   <= 1'b0;
            mrs_pend <= 1'b0;
        end else begin
            cmd_r    <= cmd_d;
            viol_q   <= viol_d;
            mrs_pend <= accept && (cmd_d == CMD_MRS);
        end
    end

    assign cmd_q     = cmd_r;
    assign bank_busy = busy;
    assign mode_word = mode_cur;
endmodule

// File: rtl/gdram_cmd_guard_chk.sv
module gdram_cmd_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        row_stb,
    input logic        col_stb,
    input logic        wr_stb,
    input logic        spec_fn,
    input logic        bank_sel,
    input logic [9:0]  addr_in,
    input logic [3:0]  cmd_q,
    input logic        viol_q,
    input logic [1:0]  bank_busy,
    input logic [10:0] mode_word,
    input logic        mode_valid
);
    a_r1_nop_clean: assert property (@(posedge clk) disable iff (rst)
        (row_stb && col_stb && wr_stb) |=> (cmd_q == 4'd0 && !viol_q));

    a_r4_access_needs_mode: assert property (@(posedge clk) disable iff (rst)
        (!mode_valid && row_stb && !col_stb && wr_stb) |=> viol_q);

    a_r5_busy_bank_blocks: assert property (@(posedge clk) disable iff (rst)
        (bank_busy[0] && !row_stb && col_stb && wr_stb && !bank_sel) |=> viol_q);

    a_r8_mrs_needs_idle: assert property (@(posedge clk) disable iff (rst)
        (!row_stb && !col_stb && !wr_stb && !spec_fn && (bank_busy != 2'b00)) |=> viol_q);

    a_r9_mrs_gap: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == 4'd7 && !viol_q && !(row_stb && col_stb && wr_stb)) |=> viol_q);

    a_r10_reject_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        viol_q |-> $stable(mode_word));

    logic unused_ok;
    assign unused_ok = ^addr_in;
endmodule

bind gdram_cmd_guard gdram_cmd_guard_chk u_chk (.*);

// File: tb/gdram_cmd_guard_bench.sv
`timescale 1ns/1ps
module gdram_cmd_guard_bench;
    localparam int TWR = 2, TRP = 3, TBPL = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic row_stb = 1'b1, col_stb = 1'b1, wr_stb = 1'b1, spec_fn = 1'b0, bank_sel = 1'b0;
    logic [9:0]  addr_in = '0;
    logic [3:0]  cmd_q;
    logic        viol_q;
    logic [1:0]  bank_busy;
    logic [10:0] mode_word;
    logic        mode_valid;

    int checks = 0, errors = 0;

    // bench reference model state
    int          m_cnt [2];
    logic [10:0] m_mode;
    logic        m_valid, m_pend;

    always #4 clk = ~clk;

    gdram_cmd_guard #(.TWR(TWR), .TRP(TRP), .TBPL(TBPL)) u_gdram_cmd_guard (
        .clk(clk), .rst(rst), .row_stb(row_stb), .col_stb(col_stb), .wr_stb(wr_stb),
        .spec_fn(spec_fn), .bank_sel(bank_sel), .addr_in(addr_in), .cmd_q(cmd_q),
        .viol_q(viol_q), .bank_busy(bank_busy), .mode_word(mode_word), .mode_valid(mode_valid));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R1 decode table
    function automatic int m_dec(input logic r, c, w, d, a9);
        case ({r, c, w})
            3'b111: return 0;
            3'b011: return d ? 10 : 1;
            3'b101: return d ? (a9 ? 6 : 5) : 2;
            3'b100: return d ? 10 : (a9 ? 4 : 3);
            3'b000: return d ? 10 : 7;
            3'b010: return 8;
            3'b001: return 9;
            default: return 10;
        endcase
    endfunction

    function automatic int beats(input logic [2:0] code);
        return 1 << code[1:0];
    endfunction

    task automatic issue(input logic r, c, w, d, b, input logic [9:0] a);
        int code;
        logic ev;
        string tag;
        code = m_dec(r, c, w, d, a[9]);
        ev = 1'b0; tag = "R1";
        if ((code == 7 || code == 9) && (m_cnt[0] != 0 || m_cnt[1] != 0)) begin
            ev = 1'b1; tag = "R8";
        end
        if (code != 0 && code != 7 && code != 9 && m_cnt[b] != 0) begin
            ev = 1'b1; tag = "R5/R7";
        end
        if (m_pend && code != 0) begin ev = 1'b1; tag = "R9"; end
        if (!m_valid && code >= 1 && code <= 6) begin ev = 1'b1; tag = "R4"; end
        if (code == 7 && !((a[2:0] <= 3 || a[2:0] == 7) && a[6:4] >= 1 && a[6:4] <= 3)) begin
            ev = 1'b1; tag = "R3";
        end
        row_stb = r; col_stb = c; wr_stb = w; spec_fn = d; bank_sel = b; addr_in = a;
        @(posedge clk);
        for (int k = 0; k < 2; k++) if (m_cnt[k] != 0) m_cnt[k]--;
        m_pend = 1'b0;
        if (code != 0 && !ev) begin
            if (code == 4 && m_mode[2:0] != 3'd7) m_cnt[b] = beats(m_mode[2:0]) + TWR + TRP - 1;
            if (code == 6) m_cnt[b] = TBPL + TRP - 1;
            if (code == 7) begin m_mode = {b, a}; m_valid = 1'b1; m_pend = 1'b1; end
        end
        @(negedge clk);
        chk("R1 cmd", 32'(cmd_q), 32'(code));
        chk({tag, " viol"}, 32'(viol_q), 32'(ev));
        chk("R5/R7/R10 busy", 32'(bank_busy), 32'({m_cnt[1] != 0, m_cnt[0] != 0}));
        chk("R2/R10 mode", 32'(mode_word), 32'(m_mode));
        chk("R2 valid", 32'(mode_valid), 32'(m_valid));
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) issue(1, 1, 1, 0, 0, 10'h000);
    endtask
    task automatic act(input logic b);   issue(0, 1, 1, 0, b, 10'h000); endtask
    task automatic wrap(input logic b);  issue(1, 0, 0, 0, b, 10'h200); endtask
    task automatic bwap(input logic b);  issue(1, 0, 1, 1, b, 10'h200); endtask
    task automatic mrs(input logic [9:0] a); issue(0, 0, 0, 0, 0, a); endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_cnt[0] = 0; m_cnt[1] = 0; m_mode = '0; m_valid = 1'b0; m_pend = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 cmd", 32'(cmd_q), 0);
        chk("R11 viol", 32'(viol_q), 0);
        chk("R11 busy", 32'(bank_busy), 0);
        chk("R11 mode", 32'(mode_word), 0);
        chk("R11 valid", 32'(mode_valid), 0);

        act(0);                  // R4: access before mode set
        mrs(10'h025);            // R3: burst code 5 rejected
        mrs(10'h021);            // burst 2, latency 2
        act(0);                  // R9: right after mode set
        nop(1);
        act(0);
        wrap(0);                 // R5: window 2+2+3 = 7
        nop(5);
        act(0);                  // t+6: one cycle early
        act(0);                  // t+7: legal
        wrap(0);
        act(1);                  // R8: other bank unaffected
        mrs(10'h021);            // R8: mode set while busy
        issue(0, 0, 1, 0, 1, 10'h000); // R8: refresh while busy
        nop(4);
        bwap(1);                 // R7: window 2+3 = 5
        nop(3);
        act(1);                  // early
        act(1);                  // legal
        nop(1);
        mrs(10'h027);            // full page
        nop(1);
        wrap(0);
        chk("R6 full page no lockout", 32'(bank_busy), 0);
        act(0);

        for (int i = 0; i < 4000; i++) begin
            int k;
            logic b;
            logic [9:0] a;
            k = int'($urandom % 16);
            b = 1'($urandom);
            a = 10'($urandom);
            case (k)
                6:  issue(0, 1, 1, 0, b, a);
                7:  issue(1, 0, 1, 0, b, a);
                8:  issue(1, 0, 0, 0, b, {1'b0, a[8:0]});
                9:  issue(1, 0, 0, 0, b, {1'b1, a[8:0]});
                10: issue(1, 0, 1, 1, b, {1'b0, a[8:0]});
                11: issue(1, 0, 1, 1, b, {1'b1, a[8:0]});
                12: begin
                    logic [2:0] bl;
                    bl = (a[2:0] > 3) ? 3'd7 : a[2:0];
                    issue(0, 0, 0, 0, b, {a[9:7], 3'(1 + ($urandom % 3)), a[3], bl});
                end
                13: issue(0, 0, 0, 0, b, a);
                14: issue(0, 1, 0, a[0], b, a);
                15: issue(0, 0, 1, a[0], b, a);
                default: issue(1, 1, 1, a[0], b, a);
            endcase
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule